// File: doc/BRIEF.md
# Memory Refresh Interval Timer

This block paces the refresh of a dynamic memory. A prescaler divides the system clock by a ratio picked from a 3-bit select field. Each prescaler tick advances an 8-bit interval counter. When the counter holds the programmed interval constant, the next tick clears it and registers a compare match. That match sets a sticky compare flag and adds one to a 10-bit refresh tally. When the tally reaches its selectable limit it clears itself and sets a sticky overflow flag.

When the refresh-enable and auto-refresh-mode inputs are both high, each match also produces a one-cycle refresh request for the command sequencer. Software reads and writes the four registers through a plain single-cycle register port. Writes take effect at the clock edge and reads are combinational.

Top module: `refresh_interval_timer`

## Requirements
- R1: After reset every register reads 0 and `rfsh_req` is low.
- R2: Register map, selected by `reg_addr`: 0 is control, 1 is the interval counter, 2 is the interval constant, 3 is the refresh tally. In the control register, bits [2:0] are the clock select, bit 3 is the limit select, bit 4 is the compare flag and bit 5 is the overflow flag. Bits above each register's implemented width read 0 and ignore writes.
- R3: Clock select codes 1 to 7 divide the clock by 4, 16, 64, 256, 1024, 2048 and 4096. Code 0 stops the counter. Any control write restarts the divider, so the first tick comes at the N-th clock edge after the write edge.
- R4: On a tick, a counter equal to the constant clears to 0, which is a compare match. Otherwise the counter increments. With constant C, the first match after a restart from 0 comes (C+1)·N edges after the control write.
- R5: A compare match sets the compare flag at the same edge.
- R6: Each compare match adds one to the refresh tally. A software write to the tally in the same cycle wins.
- R7: The limit select picks a limit of 1024 (0) or 512 (1). A match that finds the tally at or above limit−1 clears the tally to 0 and sets the overflow flag.
- R8: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. A set in the same cycle wins over a clear.
- R9: `rfsh_req` is high for exactly the one cycle that follows a match edge, and only when `rfsh_en` and `auto_mode` were both high in the match cycle.
- R10: A software write to the interval counter in a tick cycle wins. The written value is loaded, and that tick neither increments nor matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| rfsh_en | input | 1 | Refresh enable from the memory controller |
| auto_mode | input | 1 | High when auto-refresh is the selected mode |
| rfsh_req | output | 1 | One-cycle refresh request |

## Verification
The bench times the first match for several select codes and constants, down to the exact edge. A divider that is off by one or that ignores the restart would set the flag one tick early or late. Tally cases start at limit−1, above the limit and below it. An off-by-one threshold would either miss the overflow or fire it one match late. A counter write placed on the exact tick edge catches a design that lets the increment through. Flag writes with 1 catch a design that sets the flag from software. Writes of all ones catch unimplemented bits that can be written.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int TAL_W  = 10;
  localparam int DIV_W  = 12;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_CONST = 2'd2,
    A_TALLY = 2'd3
  } reg_addr_e;

  localparam int B_LIM = 3;
  localparam int B_CMF = 4;
  localparam int B_OVF = 5;

  function automatic logic [DIV_W-1:0] div_mask(input logic [2:0] sel);
    case (sel)
      3'd1:    return DIV_W'(12'h003);
      3'd2:    return DIV_W'(12'h00F);
      3'd3:    return DIV_W'(12'h03F);
      3'd4:    return DIV_W'(12'h0FF);
      3'd5:    return DIV_W'(12'h3FF);
      3'd6:    return DIV_W'(12'h7FF);
      default: return DIV_W'(12'hFFF);
    endcase
  endfunction
endpackage

// File: rtl/rit_prescaler.sv
module rit_prescaler
  import rit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       restart,
  output logic       tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = div_mask(sel);
  assign tick = (sel != 3'd0) && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/rit_interval.sv
module rit_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] limit,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic         match
);
  logic [W-1:0] cnt_q;
  logic         at_limit;

  assign at_limit = (cnt_q == limit);
  assign match    = tick && !wr_en && at_limit;
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (wr_en)    cnt_q <= wr_data;
    else if (tick)     cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rit_tally.sv
module rit_tally #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         half_lim,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] tally,
  output logic         ovf_evt
);
  localparam logic [W-1:0] FULL_M1 = {W{1'b1}};
  localparam logic [W-1:0] HALF_M1 = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] tal_q;
  logic [W-1:0] thr;

  assign thr     = half_lim ? HALF_M1 : FULL_M1;
  assign ovf_evt = inc && !wr_en && (tal_q >= thr);
  assign tally   = tal_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tal_q <= '0;
    else if (wr_en)   tal_q <= wr_data;
    else if (ovf_evt) tal_q <= '0;
    else if (inc)     tal_q <= tal_q + 1'b1;
  end
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import rit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rfsh_en,
  input  logic              auto_mode,
  output logic              rfsh_req
);
  logic [2:0]       clk_sel_q;
  logic             lim_sel_q;
  logic             cmp_flag_q;
  logic             ovf_flag_q;
  logic             req_q;
  logic [CNT_W-1:0] const_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAL_W-1:0] tally_q;
  logic             tick;
  logic             match;
  logic             ovf_evt;
  logic             ctrl_wr, cnt_wr, const_wr, tally_wr;

  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign cnt_wr   = reg_wr && (reg_addr == A_COUNT);
  assign const_wr = reg_wr && (reg_addr == A_CONST);
  assign tally_wr = reg_wr && (reg_addr == A_TALLY);

  rit_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (clk_sel_q),
    .restart (ctrl_wr),
    .tick    (tick)
  );

  rit_interval #(.W(CNT_W)) u_int (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .limit   (const_q),
    .wr_en   (cnt_wr),
    .wr_data (reg_wdata[CNT_W-1:0]),
    .cnt     (cnt_q),
    .match   (match)
  );

  rit_tally #(.W(TAL_W)) u_tal (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (match),
    .half_lim (lim_sel_q),
    .wr_en    (tally_wr),
    .wr_data  (reg_wdata[TAL_W-1:0]),
    .tally    (tally_q),
    .ovf_evt  (ovf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel_q  <= '0;
      lim_sel_q  <= 1'b0;
      cmp_flag_q <= 1'b0;
      ovf_flag_q <= 1'b0;
      const_q    <= '0;
      req_q      <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        clk_sel_q <= reg_wdata[2:0];
        lim_sel_q <= reg_wdata[B_LIM];
      end
      if (const_wr) const_q <= reg_wdata[CNT_W-1:0];

      if (match)                             cmp_flag_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata[B_CMF]) cmp_flag_q <= 1'b0;

      if (ovf_evt)                           ovf_flag_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata[B_OVF]) ovf_flag_q <= 1'b0;

      req_q <= match && rfsh_en && auto_mode;
    end
  end

  assign rfsh_req = req_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata[5:0] = {ovf_flag_q, cmp_flag_q, lim_sel_q, clk_sel_q};
      A_COUNT: reg_rdata[CNT_W-1:0] = cnt_q;
      A_CONST: reg_rdata[CNT_W-1:0] = const_q;
      default: reg_rdata[TAL_W-1:0] = tally_q;
    endcase
  end
endmodule

// File: rtl/rit_checker.sv
module rit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rfsh_req,
  input logic        rfsh_en,
  input logic        auto_mode,
  input logic        cmp_flag,
  input logic        ovf_flag,
  input logic        match,
  input logic        ovf_evt,
  input logic [7:0]  cnt,
  input logic [9:0]  tally,
  input logic [2:0]  clk_sel,
  input logic        cnt_wr,
  input logic [15:0] reg_rdata
);
  // R9
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |-> ($past(rfsh_en) && $past(auto_mode) && cmp_flag));

  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |=> !rfsh_req);

  // R4
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt == 8'd0));

  // R5
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cmp_flag);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (tally == 10'd0 && ovf_flag));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !cnt_wr) |=> $stable(cnt));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:10] == 6'd0);
endmodule

bind refresh_interval_timer rit_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rfsh_req  (rfsh_req),
  .rfsh_en   (rfsh_en),
  .auto_mode (auto_mode),
  .cmp_flag  (cmp_flag_q),
  .ovf_flag  (ovf_flag_q),
  .match     (match),
  .ovf_evt   (ovf_evt),
  .cnt       (cnt_q),
  .tally     (tally_q),
  .clk_sel   (clk_sel_q),
  .cnt_wr    (cnt_wr),
  .reg_rdata (reg_rdata)
);

// File: tb/tb_refresh_interval_timer.sv
`timescale 1ns/1ps
module tb_refresh_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        rfsh_en = 1'b0;
  logic        auto_mode = 1'b0;
  logic        rfsh_req;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  refresh_interval_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rfsh_en(rfsh_en),
    .auto_mode(auto_mode), .rfsh_req(rfsh_req)
  );

  // vector: {sel[2:0], constant[7:0], enable, auto}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {3'd1, 8'd0,  1'b1, 1'b1},
    {3'd1, 8'd3,  1'b1, 1'b0},
    {3'd2, 8'd2,  1'b0, 1'b1},
    {3'd3, 8'd1,  1'b1, 1'b1},
    {3'd1, 8'd10, 1'b0, 1'b0},
    {3'd4, 8'd0,  1'b1, 1'b1}
  };

  function automatic int divisor(input logic [2:0] s);
    case (s)
      3'd1: return 4;    3'd2: return 16;   3'd3: return 64;
      3'd4: return 256;  3'd5: return 1024; 3'd6: return 2048;
      default: return 4096;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic tally_case(input logic [9:0] init, input logic lim,
                            input logic [9:0] exp_t, input logic exp_o);
    logic [15:0] v;
    wr(2'd0, 16'h0000);
    wr(2'd3, {6'd0, init});
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd0, {12'd0, lim, 3'd1});
    repeat (4) @(negedge clk);
    rd(2'd3, v); check("R7 tally after match", v, {6'd0, exp_t});
    rd(2'd0, v); check("R7 overflow flag", {15'd0, v[5]}, {15'd0, exp_o});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reset register", v, 16'h0000);
    end
    check("R1 reset request", {15'd0, rfsh_req}, 16'h0000);

    // R3 R4 R5 R6 R9: table of match timings
    for (int i = 0; i < NV; i++) begin
      logic [2:0] s;
      logic [7:0] c;
      int cyc;
      s = VEC[i][12:10]; c = VEC[i][9:2];
      cyc = (int'(c) + 1) * divisor(s);
      wr(2'd0, 16'h0000);
      wr(2'd3, 16'h0000);
      wr(2'd1, 16'h0000);
      wr(2'd2, {8'd0, c});
      rfsh_en = VEC[i][1]; auto_mode = VEC[i][0];
      wr(2'd0, {13'd0, s});
      repeat (cyc - 1) @(negedge clk);
      rd(2'd0, v); check("R4 no match before interval", {15'd0, v[4]}, 16'h0000);
      check("R9 no early request", {15'd0, rfsh_req}, 16'h0000);
      @(negedge clk);
      rd(2'd0, v); check("R5 flag at match", {15'd0, v[4]}, 16'h0001);
      check("R9 request gating", {15'd0, rfsh_req}, {15'd0, VEC[i][1] & VEC[i][0]});
      rd(2'd1, v); check("R4 counter cleared", v, 16'h0000);
      rd(2'd3, v); check("R6 tally incremented", v, 16'h0001);
      @(negedge clk);
      check("R9 request one cycle", {15'd0, rfsh_req}, 16'h0000);
    end
    rfsh_en = 1'b0; auto_mode = 1'b0;

    // R8: flag write behaviour (compare flag is set from last vector)
    wr(2'd0, 16'h0030);
    rd(2'd0, v); check("R8 write one no effect", v, 16'h0010);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R8 write zero clears", v, 16'h0000);

    // R10: counter write on the tick edge
    wr(2'd2, 16'h00FF);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0001);
    repeat (3) @(negedge clk);
    wr(2'd1, 16'h0050);
    rd(2'd1, v); check("R10 write wins over tick", v, 16'h0050);
    repeat (3) @(negedge clk);
    rd(2'd1, v); check("R10 held until next tick", v, 16'h0050);
    @(negedge clk);
    rd(2'd1, v); check("R3 next tick increments", v, 16'h0051);

    // R7 tally limits
    tally_case(10'd1023, 1'b0, 10'd0, 1'b1);
    tally_case(10'd511,  1'b1, 10'd0, 1'b1);
    tally_case(10'd700,  1'b1, 10'd0, 1'b1);
    tally_case(10'd5,    1'b1, 10'd6, 1'b0);
    tally_case(10'd511,  1'b0, 10'd512, 1'b0);

    // R2 unimplemented bits
    wr(2'd0, 16'hFFC0);
    rd(2'd0, v); check("R2 control upper bits", v, 16'h0000);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); check("R2 constant width", v, 16'h00FF);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); check("R2 tally width", v, 16'h03FF);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); check("R2 counter width", v, 16'h00FF);

    // R3 select code 0 stops counting
    repeat (5000) @(negedge clk);
    rd(2'd1, v); check("R3 stopped counter holds", v, 16'h00FF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule